// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block keeps one captured time value per traffic direction. A transmit unit and a receive unit each watch a capture strobe that marks a packet crossing the capture point. When a unit is enabled, its latch is empty and the packet qualifies, the unit copies the running 64-bit time counter into its stamp register and raises its valid flag. From then on the unit is locked, and every later strobe is dropped without effect.

Software reads a stamp through a small register bus, taking the low word first and then the high word. Reading the high word frees the latch. That single read is also enough to recover a latch that nobody ever drained. On the receive side a selector chooses which packet classes are stamped. The transmit side stamps every strobed packet, because at most one outgoing packet carries a stamp request at a time.

Top module: `ts_capture`

## Requirements
- R1: After reset both valid flags and both stamps are 0 and both enable bits are 0. The receive selector resets to 0 and the transmit selector reads as 2. The transmit control register therefore reads 4 and every other register reads 0.
- R2: With its unit enabled and valid clear, a strobe samples `time_now` on the rising edge where the strobe is high. Valid reads 1 from the next cycle on.
- R3: While valid is set, further strobes on that direction are dropped. Both the stamp and valid stay unchanged.
- R4: A read (`reg_rd`=1) of a high-word address clears that direction's valid flag at the clock edge. A read of the low word or of the control register leaves valid set.
- R5: Address bit 2 selects the direction (0 transmit, 1 receive). Bits 1:0 select the control register (0), stamp bits 31:0 (1) or stamp bits 63:32 (2). Code 3 reads 0. The control register reads {valid at bit 3, selector at bits 2:1, enable at bit 0}.
- R6: With the enable bit cleared (write data bit 0 = 0), strobes capture nothing.
- R7: The receive selector is written from write data bits 2:1, and `rx_cls` gives the packet class (0 other, 1 v1 event over L4, 2 v2 event at L2 or L4). Selector 0 stamps class 1 only, selector 1 stamps class 2 only, selector 2 stamps every class, and selector 3 stamps none.
- R8: Writing the control register, including a selector change, neither clears valid nor alters a held stamp.
- R9: The two directions are independent. A capture, lock or release on one direction leaves the other unchanged.
- R10: A strobe in the same cycle as the releasing high-word read is dropped. The first strobe after that read captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Running time counter |
| tx_evt | input | 1 | Transmit capture strobe |
| rx_evt | input | 1 | Receive capture strobe |
| rx_cls | input | 2 | Class of the strobed receive packet |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data: enable bit 0, selector bits 2:1 |
| reg_rd | input | 1 | Read strobe; releases the latch on a high-word address |
| reg_rdata | output | 32 | Read data for `reg_addr` |

## Verification
The receive filter is tried with every pairing of the four selector codes and the three packet classes. This separates a filter that admits too much from one that admits too little.

The transmit path is checked four ways:
- a strobe while disabled, which catches a missing enable gate;
- a second strobe while the latch is locked, which catches overwrite-while-locked;
- a low-word read, which catches a release on the wrong word;
- a strobe coinciding with the releasing read, which catches a lock ordering error.

Interleaved captures on the two directions, and a selector rewrite while a stamp is held, show whether state leaks between directions or is lost on a control write.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int SEL_W = 2;
  localparam int CLS_W = 2;
  localparam int CTL_W = SEL_W + 1;

  // receive class selector codes
  localparam logic [SEL_W-1:0] SEL_V1_L4  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_V2_EVT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_ANY    = 2'd2;
  localparam logic [SEL_W-1:0] SEL_NONE   = 2'd3;

  // packet class codes
  localparam logic [CLS_W-1:0] CLS_OTHER  = 2'd0;
  localparam logic [CLS_W-1:0] CLS_V1_L4  = 2'd1;
  localparam logic [CLS_W-1:0] CLS_V2_EVT = 2'd2;

  // register offsets inside one direction
  localparam logic [1:0] OFS_CTL = 2'd0;
  localparam logic [1:0] OFS_LO  = 2'd1;
  localparam logic [1:0] OFS_HI  = 2'd2;

  function automatic logic sel_match(input logic [SEL_W-1:0] sel,
                                     input logic [CLS_W-1:0] cls);
    case (sel)
      SEL_V1_L4:  return cls == CLS_V1_L4;
      SEL_V2_EVT: return cls == CLS_V2_EVT;
      SEL_ANY:    return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ts_unit.sv
module ts_unit
  import ts_pkg::*;
#(
  parameter int TW = 64,
  parameter logic [SEL_W-1:0] SEL_RST = SEL_V1_L4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wd,
  input  logic             strobe,
  input  logic [CLS_W-1:0] cls,
  input  logic             rel,
  input  logic [TW-1:0]    now,
  output logic [TW-1:0]    stamp,
  output logic             valid,
  output logic             en,
  output logic [SEL_W-1:0] sel
);
  logic qualify;
  logic fire;
  logic drop;

  assign qualify = sel_match(sel, cls);
  assign fire    = en && strobe && qualify && !valid;
  assign drop    = strobe && valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      sel   <= SEL_RST;
      valid <= 1'b0;
      stamp <= '0;
    end else begin
      if (ctl_we) begin
        en  <= ctl_wd[0];
        sel <= ctl_wd[CTL_W-1:1];
      end
      if (fire) begin
        stamp <= now;
        valid <= 1'b1;
      end else if (rel) begin
        valid <= 1'b0;
      end
    end
  end

  assert_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> valid && stamp == $past(now));
  assert_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !rel |=> valid && $stable(stamp));
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rel && valid |=> !valid);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && !(en && strobe) |=> !valid && $stable(stamp));
  assert_ctl_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && valid && !rel |=> valid);
endmodule

// File: rtl/ts_regmux.sv
module ts_regmux
  import ts_pkg::*;
#(
  parameter int TW    = 64,
  parameter int NDIR  = 2,
  parameter int AW    = 3,
  localparam int DW   = TW / 2
) (
  input  logic                      rst_n,
  input  logic                      clk,
  input  logic [AW-1:0]             addr,
  input  logic                      rd,
  input  logic [NDIR-1:0][TW-1:0]   stamp,
  input  logic [NDIR-1:0]           valid,
  input  logic [NDIR-1:0]           en,
  input  logic [NDIR-1:0][SEL_W-1:0] sel,
  output logic [DW-1:0]             rdata,
  output logic [NDIR-1:0]           rel
);
  logic          dir;
  logic [1:0]    ofs;

  assign dir = addr[AW-1];
  assign ofs = addr[1:0];

  for (genvar g = 0; g < NDIR; g++) begin : g_rel
    assign rel[g] = rd && (dir == g[0]) && (ofs == OFS_HI);
  end

  always_comb begin
    case (ofs)
      OFS_CTL: rdata = DW'({valid[dir], sel[dir], en[dir]});
      OFS_LO:  rdata = stamp[dir][DW-1:0];
      OFS_HI:  rdata = stamp[dir][TW-1:DW];
      default: rdata = '0;
    endcase
  end

  assert_one_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel));
endmodule

// File: rtl/ts_capture.sv
module ts_capture
  import ts_pkg::*;
#(
  parameter int TW = 64,
  parameter int AW = 3,
  localparam int DW   = TW / 2,
  localparam int NDIR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    time_now,
  input  logic             tx_evt,
  input  logic             rx_evt,
  input  logic [CLS_W-1:0] rx_cls,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             reg_rd,
  output logic [DW-1:0]    reg_rdata
);
  logic [NDIR-1:0][TW-1:0]    stamp;
  logic [NDIR-1:0]            valid;
  logic [NDIR-1:0]            en;
  logic [NDIR-1:0][SEL_W-1:0] sel;
  logic [NDIR-1:0]            rel;
  logic [NDIR-1:0]            strobe;
  logic [NDIR-1:0][CLS_W-1:0] cls;
  logic [NDIR-1:0]            ctl_we;

  assign strobe = {rx_evt, tx_evt};
  assign cls    = {rx_cls, CLS_OTHER};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    localparam bit IS_RX = (g == 1);
    logic [CTL_W-1:0] wd;
    assign ctl_we[g] = reg_wr && (reg_addr[AW-1] == g[0]) && (reg_addr[1:0] == OFS_CTL);
    if (IS_RX) begin : g_sel_free
      assign wd = ctl_wdata;
    end else begin : g_sel_fixed
      assign wd = {SEL_ANY, ctl_wdata[0]};
    end
    ts_unit #(.TW(TW), .SEL_RST(IS_RX ? SEL_V1_L4 : SEL_ANY)) u_unit (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_we (ctl_we[g]),
      .ctl_wd (wd),
      .strobe (strobe[g]),
      .cls    (cls[g]),
      .rel    (rel[g]),
      .now    (time_now),
      .stamp  (stamp[g]),
      .valid  (valid[g]),
      .en     (en[g]),
      .sel    (sel[g])
    );
  end

  ts_regmux #(.TW(TW), .NDIR(NDIR), .AW(AW)) u_mux (
    .rst_n (rst_n),
    .clk   (clk),
    .addr  (reg_addr),
    .rd    (reg_rd),
    .stamp (stamp),
    .valid (valid),
    .en    (en),
    .sel   (sel),
    .rdata (reg_rdata),
    .rel   (rel)
  );

  assert_dir_indep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_evt && !rel[1] && !ctl_we[1] |=> $stable(valid[1]) && $stable(stamp[1]));
endmodule

// File: tb/sim_ts_capture.sv
module sim_ts_capture;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] time_now = '0;
  logic        tx_evt = 0, rx_evt = 0;
  logic [1:0]  rx_cls = 0;
  logic [2:0]  reg_addr = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  ctl_wdata = 0;
  logic [31:0] reg_rdata;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ts_capture u0 (.clk(clk), .rst_n(rst_n), .time_now(time_now), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .rx_cls(rx_cls), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .ctl_wdata(ctl_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  // address map: bit2 = direction, bits1:0 = ctl/lo/hi
  localparam logic [2:0] TXC = 3'd0, TXL = 3'd1, TXH = 3'd2;
  localparam logic [2:0] RXC = 3'd4, RXL = 3'd5, RXH = 3'd6;

  // rx filter table: {selector, class, expect capture}
  localparam logic [4:0] FVEC [12] = '{
    {2'd0, 2'd0, 1'b0}, {2'd0, 2'd1, 1'b1}, {2'd0, 2'd2, 1'b0},
    {2'd1, 2'd0, 1'b0}, {2'd1, 2'd1, 1'b0}, {2'd1, 2'd2, 1'b1},
    {2'd2, 2'd0, 1'b1}, {2'd2, 2'd1, 1'b1}, {2'd2, 2'd2, 1'b1},
    {2'd3, 2'd0, 1'b0}, {2'd3, 2'd1, 1'b0}, {2'd3, 2'd2, 1'b0}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr_ctl(input logic [2:0] a, input logic [2:0] d);
    @(negedge clk);
    reg_addr = a; ctl_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic pop(input logic [2:0] a);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic tx_fire(input logic [63:0] t);
    @(negedge clk);
    time_now = t; tx_evt = 1;
    @(negedge clk);
    tx_evt = 0; time_now = t + 64'd1000;
  endtask

  task automatic rx_fire(input logic [63:0] t, input logic [1:0] c);
    @(negedge clk);
    time_now = t; rx_cls = c; rx_evt = 1;
    @(negedge clk);
    rx_evt = 0; time_now = t + 64'd1000;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    peek(TXC, d); chk("R1 tx ctl", d, 32'h4);
    peek(TXL, d); chk("R1 tx lo", d, 0);
    peek(TXH, d); chk("R1 tx hi", d, 0);
    peek(RXC, d); chk("R1 rx ctl", d, 0);
    peek(RXL, d); chk("R1 rx lo", d, 0);
    peek(RXH, d); chk("R1 rx hi", d, 0);
    peek(3'd3, d); chk("R5 unused offset", d, 0);

    // R7 filter table
    for (int i = 0; i < 12; i++) begin
      logic [1:0] s, c;
      logic e;
      {s, c, e} = FVEC[i];
      t = 64'h0000_0100_0000_0000 + 64'(i * 17);
      wr_ctl(RXC, {s, 1'b1});
      rx_fire(t, c);
      peek(RXC, d); chk("R7 rx valid per selector/class", d, {28'd0, e, s, 1'b1});
      if (e) begin
        peek(RXL, d); chk("R7 rx stamp lo", d, t[31:0]);
        peek(RXH, d); chk("R7 rx stamp hi", d, t[63:32]);
      end
      pop(RXH);
      peek(RXC, d); chk("R4 rx released", d, {28'd0, 1'b0, s, 1'b1});
    end

    // R6 disabled tx
    tx_fire(64'h55);
    peek(TXC, d); chk("R6 tx disabled no capture", d, 32'h4);

    // R2 R5 capture and readout
    wr_ctl(TXC, 3'b111);
    peek(TXC, d); chk("R7 tx selector fixed", d, 32'h5);
    tx_fire(64'hDEAD_BEEF_1234_5678);
    peek(TXC, d); chk("R2 tx valid", d, 32'hD);
    peek(TXL, d); chk("R5 tx lo", d, 32'h1234_5678);
    peek(TXH, d); chk("R5 tx hi", d, 32'hDEAD_BEEF);

    // R3 lock
    tx_fire(64'h1111_2222_3333_4444);
    peek(TXL, d); chk("R3 locked lo", d, 32'h1234_5678);
    peek(TXH, d); chk("R3 locked hi", d, 32'hDEAD_BEEF);

    // R4 low read does not release
    pop(TXL);
    peek(TXC, d); chk("R4 lo read keeps valid", d, 32'hD);

    // R9 rx capture while tx locked
    wr_ctl(RXC, {2'd2, 1'b1});
    rx_fire(64'h0000_0007_0000_0009, 2'd0);
    peek(RXL, d); chk("R9 rx captured", d, 32'h9);
    peek(TXL, d); chk("R9 tx untouched", d, 32'h1234_5678);
    pop(RXH);
    peek(TXC, d); chk("R9 tx valid after rx release", d, 32'hD);

    // R10 strobe with releasing read is dropped
    @(negedge clk);
    reg_addr = TXH; reg_rd = 1; time_now = 64'h77; tx_evt = 1;
    @(negedge clk);
    reg_rd = 0; tx_evt = 0;
    peek(TXC, d); chk("R10 coincident strobe dropped", d, 32'h5);
    peek(TXL, d); chk("R10 stamp kept", d, 32'h1234_5678);
    tx_fire(64'h0000_00AA_0000_00BB);
    peek(TXL, d); chk("R10 next capture lo", d, 32'hBB);
    peek(TXH, d); chk("R10 next capture hi", d, 32'hAA);

    // R8 selector change keeps latched stamp
    wr_ctl(RXC, {2'd2, 1'b1});
    rx_fire(64'h0000_0003_0000_0004, 2'd1);
    wr_ctl(RXC, {2'd3, 1'b1});
    peek(RXC, d); chk("R8 valid kept after selector write", d, 32'hF);
    peek(RXL, d); chk("R8 stamp kept", d, 32'h4);
    pop(RXH);

    // R6 disable after release
    pop(TXH);
    wr_ctl(TXC, 3'b000);
    tx_fire(64'h99);
    peek(TXC, d); chk("R6 tx disabled again", d, 32'h4);
    peek(TXL, d); chk("R6 stamp unchanged", d, 32'hBB);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule